// File: doc/BRIEF.md
# Keyed Flash Area Remapping Controller

This block sits between the data-side memory port of a processor and a flash array. It decides where a data-side transfer to the upper half of a 64 KB address space goes. In the default mapping, the upper window of the data space has no flash behind it. Transfers that land there are flagged as unmapped and never reach the array. In the remapped state, the upper half of code-side flash shows through that same data window. Each transfer there becomes one physical flash request, and its offset is the address with the top bit removed. The data window and the upper code region are two views of the same physical flash range, so both must resolve to the same offset.

The mapping changes through two steps on a small register write bus. First, software writes the wanted area code into a staging register. Nothing changes at that point. Then software writes a fixed key byte to a separate arm register, and only then is the staged code copied into the live mapping. Any other byte on the arm register is dropped. A staged code that names a reserved area is never made live. Both the staged and the live codes are brought out on readback pins.

Top module: `flash_area_remap`

## Requirements
- R1: After reset, the staged area code (`stage_area`) and the live area code (`live_area`) both read 2'b00.
- R2: A write with `cfg_reg`=0 loads `cfg_wdata[1:0]` into `stage_area`, visible from the next cycle on. `live_area` does not change because of it.
- R3: A write with `cfg_reg`=1 and `cfg_wdata`=8'hD5 copies `stage_area` into `live_area` from the next cycle on, provided `stage_area` is 2'b00 or 2'b10.
- R4: A write with `cfg_reg`=1 and any byte other than 8'hD5 changes neither `live_area` nor `stage_area`.
- R5: Committing a reserved staged code (2'b01 or 2'b11) leaves `live_area` unchanged. `live_area` only ever holds 2'b00 or 2'b10.
- R6: While `live_area`=2'b10, a valid access with `acc_addr[15]`=1 raises `fl_req` in the same cycle. It puts `acc_addr`-0x8000 on the 15-bit `fl_offset`, copies `acc_write` to `fl_write` and `acc_wdata` to `fl_wdata`, and keeps `acc_unmapped` low.
- R7: While `live_area`=2'b00, a valid access with `acc_addr[15]`=1 raises `acc_unmapped` in the same cycle and leaves `fl_req` low.
- R8: A valid access with `acc_addr[15]`=0, or any cycle with `acc_valid` low, raises neither `fl_req` nor `acc_unmapped`.
- R9: An access in the same cycle as a committing key write is steered by the mapping that was live before that write.
- R10: Staging 2'b00 and then committing with 8'hD5 returns a remapped block to the default mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_reg | input | 1 | Register index: 0 staging, 1 arm/key |
| cfg_wdata | input | 8 | Register write byte |
| stage_area | output | 2 | Readback of the staged area code |
| live_area | output | 2 | Readback of the live area code |
| acc_valid | input | 1 | Data-side access present |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | 16 | Data-side byte address |
| acc_wdata | input | 8 | Data-side write byte |
| fl_req | output | 1 | Physical flash request |
| fl_write | output | 1 | Physical request is a write |
| fl_offset | output | 15 | Physical flash offset |
| fl_wdata | output | 8 | Write byte to flash |
| acc_unmapped | output | 1 | Access hit the window with no flash mapped |

## Verification
Two things can happen in one cycle: a key write that commits a new mapping, and a data access into the upper window. The bench drives both in the same cycle with the key byte and an address of 0x9234. While the commit is pending, the access must still follow the old mapping. Starting from the default mapping, that means an unmapped flag and no flash request. On the next cycle, the same address must turn into a physical request at offset 0x1234. The reverse case, a commit back to default during an access, is judged the same way.

// File: rtl/flash_remap_pkg.sv
// Package: shared constants and types for the flash area remapping block.
// Assumes a single byte-wide register write bus with one index bit.
package flash_remap_pkg;

    // Area codes held in the staging and live registers
    typedef enum logic [1:0] {
        AREA_DEFAULT = 2'b00,
        AREA_RSVD_A  = 2'b01,
        AREA_CODE_HI = 2'b10,
        AREA_RSVD_B  = 2'b11
    } area_code_t;

    // Register index decoded from the one-bit register select
    typedef enum logic {
        REG_STAGE = 1'b0,
        REG_ARM   = 1'b1
    } cfg_index_t;

    localparam logic [7:0] ARM_KEY = 8'hD5;

    // True for area codes allowed to become live
    function automatic logic area_is_legal(input logic [1:0] code);
        return (code == AREA_DEFAULT) || (code == AREA_CODE_HI);
    endfunction

endpackage

// File: rtl/remap_key_match.sv
// Module: remap_key_match
// Turns a register write into two single-cycle pulses, one that stages an
// area code and one that arms a commit. The arm pulse fires only when the
// written byte equals the key. Assumes the write strobe lasts one cycle per write.
module remap_key_match
    import flash_remap_pkg::*;
#(
    parameter int          DATA_W = 8,
    parameter logic [7:0]  KEY    = ARM_KEY
) (
    input  logic              we,
    input  logic              reg_idx,
    input  logic [DATA_W-1:0] wdata,
    output logic              stage_pulse,
    output logic              commit_pulse
);

    localparam int KEY_W = 8;

    logic key_hit;

    // Compare the full written byte with the key
    always_comb begin
        key_hit = (wdata[KEY_W-1:0] == KEY);
    end

    // Route the strobe by register index
    always_comb begin
        stage_pulse  = we && (cfg_index_t'(reg_idx) == REG_STAGE);
        commit_pulse = we && (cfg_index_t'(reg_idx) == REG_ARM) && key_hit;
    end

endmodule

// File: rtl/remap_area_regs.sv
// Module: remap_area_regs
// Holds the staged and the live area codes. A stage pulse loads the staged
// code. A commit pulse copies it to the live code, unless it is reserved.
// Assumes the two pulses are never high together (one write bus).
module remap_area_regs
    import flash_remap_pkg::*;
#(
    parameter int AREA_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stage_pulse,
    input  logic              commit_pulse,
    input  logic [AREA_W-1:0] stage_value,
    output logic [AREA_W-1:0] staged,
    output logic [AREA_W-1:0] live
);

    logic commit_ok;

    // Commit only when the staged code is a legal mapping
    always_comb begin
        commit_ok = commit_pulse && area_is_legal(staged);
    end

    // Staging register: loaded by a write to the staging index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged <= AREA_DEFAULT;
        end else if (stage_pulse) begin
            staged <= stage_value;
        end
    end

    // Live register: loaded from the staging register on a legal commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live <= AREA_DEFAULT;
        end else if (commit_ok) begin
            live <= staged;
        end
    end

    AST_LIVE_ONLY_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        area_is_legal(live)); // R5
    AST_STAGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !stage_pulse |=> $stable(staged)); // R2
    AST_LIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_pulse |=> $stable(live)); // R4
    AST_COMMIT_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_pulse && area_is_legal(staged)) |=> (live == $past(staged))); // R3

endmodule

// File: rtl/remap_steer.sv
// Module: remap_steer
// Steers one data-side access according to the live area code. In the
// upper window it either forwards the access to flash or flags it as
// unmapped. Below the window it produces nothing. Purely combinational.
// Assumes the window is the upper half of the address space.
module remap_steer
    import flash_remap_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int AREA_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AREA_W-1:0] live,
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              req,
    output logic              req_write,
    output logic [ADDR_W-2:0] offset,
    output logic [DATA_W-1:0] req_wdata,
    output logic              unmapped
);

    localparam int OFF_W = ADDR_W - 1;

    logic in_window;
    logic mapped;

    // Window hit is the top address bit; mapping is live code upper-code
    always_comb begin
        in_window = valid && addr[ADDR_W-1];
        mapped    = (live == AREA_CODE_HI);
    end

    // Issue the flash request or the unmapped flag for window hits
    always_comb begin
        req       = in_window && mapped;
        unmapped  = in_window && !mapped;
        req_write = req && write;
        offset    = addr[OFF_W-1:0];
        req_wdata = wdata;
    end

    AST_REQ_NEEDS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (live == AREA_CODE_HI)); // R6
    AST_UNMAPPED_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> (live == AREA_DEFAULT)); // R7
    AST_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid || !addr[ADDR_W-1]) |-> (!req && !unmapped)); // R8
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && unmapped)); // R6

endmodule

// File: rtl/flash_area_remap.sv
// Module: flash_area_remap
// Top level of the keyed flash area remapping controller. Writes on the
// register bus stage an area code and commit it with a key byte. The live
// code then steers data-side accesses in the upper window to flash or
// marks them unmapped. Assumes a synchronous active-low reset.
module flash_area_remap
    import flash_remap_pkg::*;
#(
    parameter int         ADDR_W = 16,
    parameter int         DATA_W = 8,
    parameter logic [7:0] KEY    = ARM_KEY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_reg,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [1:0]        stage_area,
    output logic [1:0]        live_area,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              fl_req,
    output logic              fl_write,
    output logic [ADDR_W-2:0] fl_offset,
    output logic [DATA_W-1:0] fl_wdata,
    output logic              acc_unmapped
);

    localparam int AREA_W = 2;

    logic stage_pulse;
    logic commit_pulse;

    remap_key_match #(
        .DATA_W (DATA_W),
        .KEY    (KEY)
    ) u_key (
        .we           (cfg_we),
        .reg_idx      (cfg_reg),
        .wdata        (cfg_wdata),
        .stage_pulse  (stage_pulse),
        .commit_pulse (commit_pulse)
    );

    remap_area_regs #(
        .AREA_W (AREA_W)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .stage_pulse  (stage_pulse),
        .commit_pulse (commit_pulse),
        .stage_value  (cfg_wdata[AREA_W-1:0]),
        .staged       (stage_area),
        .live         (live_area)
    );

    remap_steer #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .AREA_W (AREA_W)
    ) u_steer (
        .clk       (clk),
        .rst_n     (rst_n),
        .live      (live_area),
        .valid     (acc_valid),
        .write     (acc_write),
        .addr      (acc_addr),
        .wdata     (acc_wdata),
        .req       (fl_req),
        .req_write (fl_write),
        .offset    (fl_offset),
        .req_wdata (fl_wdata),
        .unmapped  (acc_unmapped)
    );

    AST_NON_KEY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_reg && cfg_wdata != KEY) |=> $stable(live_area)); // R4
    AST_OLD_MAP_STEERS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_addr[ADDR_W-1] && commit_pulse && live_area == AREA_DEFAULT)
        |-> acc_unmapped); // R9

endmodule

// File: tb/tb_flash_area_remap.sv
module tb_flash_area_remap;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_reg = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [1:0]  stage_area;
    logic [1:0]  live_area;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [7:0]  acc_wdata = '0;
    logic        fl_req;
    logic        fl_write;
    logic [14:0] fl_offset;
    logic [7:0]  fl_wdata;
    logic        acc_unmapped;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    flash_area_remap dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata),
        .stage_area(stage_area), .live_area(live_area),
        .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .fl_req(fl_req), .fl_write(fl_write), .fl_offset(fl_offset),
        .fl_wdata(fl_wdata), .acc_unmapped(acc_unmapped)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One register write, driven after a falling edge, taken at the next rise
    task automatic cfg_write(input logic idx, input logic [7:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_reg = idx; cfg_wdata = val;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
    endtask

    // Present one access mid-cycle and check the combinational outcome
    task automatic access(input string req, input logic wr, input logic [15:0] a,
                          input logic [7:0] d, input logic exp_req,
                          input logic exp_unm);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_wdata = d;
        #1;
        check(req, "fl_req", fl_req, exp_req);
        check(req, "acc_unmapped", acc_unmapped, exp_unm);
        if (exp_req) begin
            check(req, "fl_offset", fl_offset, a - 16'h8000);
            check(req, "fl_write", fl_write, wr);
            check(req, "fl_wdata", fl_wdata, d);
        end
        @(posedge clk);
        #1;
        acc_valid = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        check("R1", "stage after reset", stage_area, 2'b00);
        check("R1", "live after reset", live_area, 2'b00);
        access("R7", 1'b0, 16'h8000, 8'h00, 1'b0, 1'b1);
    endtask

    task automatic t_stage_only();
        cfg_write(1'b0, 8'hFE);
        check("R2", "staged low bits", stage_area, 2'b10);
        check("R2", "live untouched", live_area, 2'b00);
        access("R2", 1'b0, 16'hC000, 8'h00, 1'b0, 1'b1);
    endtask

    task automatic t_bad_key();
        cfg_write(1'b1, 8'hD4);
        check("R4", "live after D4", live_area, 2'b00);
        check("R4", "stage after D4", stage_area, 2'b10);
        cfg_write(1'b1, 8'h55);
        check("R4", "live after 55", live_area, 2'b00);
        access("R4", 1'b1, 16'hFFFF, 8'h11, 1'b0, 1'b1);
    endtask

    task automatic t_commit_map();
        cfg_write(1'b1, 8'hD5);
        check("R3", "live after key", live_area, 2'b10);
        check("R3", "stage kept", stage_area, 2'b10);
        access("R6", 1'b0, 16'h8000, 8'h00, 1'b1, 1'b0);
        access("R6", 1'b1, 16'hFFFF, 8'hA5, 1'b1, 1'b0);
        access("R6", 1'b1, 16'hB3C1, 8'h3C, 1'b1, 1'b0);
    endtask

    task automatic t_low_half();
        access("R8", 1'b0, 16'h7FFF, 8'h00, 1'b0, 1'b0);
        access("R8", 1'b1, 16'h0000, 8'h77, 1'b0, 1'b0);
        @(negedge clk);
        acc_valid = 1'b0; acc_addr = 16'h9000;
        #1;
        check("R8", "idle fl_req", fl_req, 1'b0);
        check("R8", "idle unmapped", acc_unmapped, 1'b0);
    endtask

    task automatic t_reserved();
        cfg_write(1'b0, 8'h01);
        cfg_write(1'b1, 8'hD5);
        check("R5", "live after rsvd 01", live_area, 2'b10);
        cfg_write(1'b0, 8'h03);
        cfg_write(1'b1, 8'hD5);
        check("R5", "live after rsvd 11", live_area, 2'b10);
        check("R5", "stage holds 11", stage_area, 2'b11);
        access("R5", 1'b0, 16'h8123, 8'h00, 1'b1, 1'b0);
    endtask

    // Commit and access in the same cycle: old mapping steers that access
    task automatic t_same_cycle(input logic [7:0] target, input logic old_mapped);
        cfg_write(1'b0, target);
        @(negedge clk);
        cfg_we = 1'b1; cfg_reg = 1'b1; cfg_wdata = 8'hD5;
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 16'h9234;
        #1;
        check("R9", "same-cycle fl_req", fl_req, old_mapped);
        check("R9", "same-cycle unmapped", acc_unmapped, !old_mapped);
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        check("R9", "next-cycle fl_req", fl_req, !old_mapped);
        check("R9", "next-cycle unmapped", acc_unmapped, old_mapped);
        if (!old_mapped) check("R9", "next-cycle offset", fl_offset, 15'h1234);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic t_restore();
        cfg_write(1'b0, 8'h00);
        check("R10", "still mapped before key", live_area, 2'b10);
        cfg_write(1'b1, 8'hD5);
        check("R10", "live restored", live_area, 2'b00);
        access("R10", 1'b0, 16'hA000, 8'h00, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_stage_only();
        t_bad_key();
        t_commit_map();
        t_low_half();
        t_reserved();
        t_restore();
        t_same_cycle(8'h02, 1'b0);
        t_same_cycle(8'h00, 1'b1);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual=hung expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule